// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken by running two direction predictors side by side and letting a third table decide which one to trust. The first component keeps one 2-bit saturating counter per entry and is addressed with the low bits of the branch address, so it follows a branch's own habits. The second component keeps a separate counter array and is addressed with a shift register of the most recent resolved outcomes, so it follows branches whose direction depends on the path that led to them. A third array of 2-bit counters, addressed like the first component, learns for each branch which component has been right more often and picks that component's answer.

A fetch stage asks for a prediction by presenting the branch index on the lookup port and receives the chosen direction, together with both component guesses, one cycle later. When the branch resolves, the back end reports its index and real outcome on the training port. Both components are trained on every resolved branch, the selector moves only when the two components disagreed in correctness, and the outcome history then shifts. After reset the block first walks every table entry to a known value and only then accepts traffic.

Top module: `tourney_bp`

## Requirements
- R1: After reset `ready` stays low for exactly 2^max(IDX_W,HIST_W) clock cycles while every entry of all three tables is set to 01 and the outcome history is cleared to zero; `ready` then rises and stays high until the next reset.
- R2: A lookup presented with `pred_req` high while `ready` is high produces `pred_vld` high in the following cycle, carrying `pred_dir`, `pred_loc` and `pred_glb`; `pred_vld` is low in every other cycle.
- R3: `pred_loc` is bit 1 of the per-address counter selected by `pred_pc` (counter value 10 or 11 means taken, 1 on the output).
- R4: `pred_glb` is bit 1 of the history-indexed counter selected by the history value present in the cycle the lookup is presented.
- R5: `pred_dir` equals `pred_glb` when the selector counter at `pred_pc` is 10 or 11, and equals `pred_loc` when it is 00 or 01.
- R6: On training, the selector counter steps up by one (saturating at 11) when only the history-indexed component predicted the outcome correctly, steps down by one (saturating at 00) when only the per-address component did, and is left unchanged when both were right or both were wrong.
- R7: Every training event moves both component counters one step toward the real outcome (up on taken, down on not taken, saturating at 11 and 00), no matter which component the selector favours.
- R8: A training event in cycle t reads and writes the history-indexed counter with the history value of cycle t; the history then shifts left by one with the outcome entering bit 0, and that new value is used from cycle t+1 on.
- R9: Counter changes from a training event in cycle t are seen by lookups presented in cycle t+2 or later, not by a lookup in cycle t+1; training events on consecutive cycles to the same entries accumulate as if applied one after another.
- R10: While `ready` is low, lookups produce no `pred_vld` and training events change neither the tables nor the history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ready | output | 1 | High once the table initialisation walk has finished |
| pred_req | input | 1 | Lookup request |
| pred_pc | input | IDX_W | Low branch address bits for the lookup |
| pred_vld | output | 1 | Lookup result valid (one cycle after the request) |
| pred_dir | output | 1 | Final predicted direction, 1 = taken |
| pred_loc | output | 1 | Per-address component guess |
| pred_glb | output | 1 | History-indexed component guess |
| upd_req | input | 1 | Training event for a resolved branch |
| upd_pc | input | IDX_W | Low branch address bits of the resolved branch |
| upd_taken | input | 1 | Real outcome of the resolved branch, 1 = taken |

## Verification
The bench aims at the selector rule: a branch where only the history component was right must flip the final answer to that component, and a design that moved the selector on agreement, or moved it the wrong way, would keep returning the per-address guess. It sends back-to-back training events to one entry, where a design without write forwarding would lose an increment and later report a not-taken guess for a branch that is strongly taken. It also probes the exact visibility window, a lookup one cycle after training must still show the old counter while one two cycles after must show the new one, and it issues traffic during the initialisation walk, which a design that did not gate on `ready` would let into the tables. A long mixed phase with a mid-run reset keeps the behavioural model in lockstep with the outputs on every clock.

// File: rtl/tbp_pkg.sv
package tbp_pkg;

  typedef logic [1:0] ctr2_t;

  localparam ctr2_t CTR_INIT = 2'b01;

  // one saturating step of a 2-bit counter
  function automatic ctr2_t ctr_step(input ctr2_t c, input logic up);
    ctr2_t r;
    if (up) r = (c == 2'b11) ? c : c + 2'b01;
    else    r = (c == 2'b00) ? c : c - 2'b01;
    return r;
  endfunction

  // selector moves toward the component that alone was right
  function automatic ctr2_t sel_step(input ctr2_t c, input logic loc_ok,
                                     input logic glb_ok);
    ctr2_t r;
    r = c;
    if (glb_ok && !loc_ok) r = ctr_step(c, 1'b1);
    if (loc_ok && !glb_ok) r = ctr_step(c, 1'b0);
    return r;
  endfunction

endpackage

// File: rtl/tbp_ctr_table.sv
module tbp_ctr_table
  import tbp_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic [AW-1:0] lk_addr,
  output logic          lk_dir,
  input  logic [AW-1:0] tr_addr,
  output ctr2_t         tr_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  ctr2_t         wr_data
);

  localparam int DEPTH = 1 << AW;

  ctr2_t mem [DEPTH];

  // read-first, registered reads on both read ports
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    lk_dir  <= mem[lk_addr][1];
    tr_data <= mem[tr_addr];
  end

endmodule

// File: rtl/tbp_hist_reg.sv
module tbp_hist_reg #(
  parameter int HW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          shift_en,
  input  logic          bit_in,
  output logic [HW-1:0] hist
);

  always_ff @(posedge clk) begin
    if (rst)           hist <= '0;
    else if (shift_en) hist <= {hist[HW-2:0], bit_in};
  end

endmodule

// File: rtl/tbp_init_sweep.sv
module tbp_init_sweep #(
  parameter int SW = 12
) (
  input  logic          clk,
  input  logic          rst,
  output logic          busy,
  output logic [SW-1:0] idx
);

  localparam logic [SW-1:0] LAST = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (busy) begin
      if (idx == LAST) busy <= 1'b0;
      idx <= idx + 1'b1;
    end
  end

endmodule

// File: rtl/tourney_bp.sv
module tourney_bp
  import tbp_pkg::*;
#(
  parameter int IDX_W  = 12,
  parameter int HIST_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  output logic             ready,
  input  logic             pred_req,
  input  logic [IDX_W-1:0] pred_pc,
  output logic             pred_vld,
  output logic             pred_dir,
  output logic             pred_loc,
  output logic             pred_glb,
  input  logic             upd_req,
  input  logic [IDX_W-1:0] upd_pc,
  input  logic             upd_taken
);

  localparam int SW = (IDX_W > HIST_W) ? IDX_W : HIST_W;

  logic              busy;
  logic [SW-1:0]     sweep_idx;
  logic [HIST_W-1:0] ghist;
  logic              lk_go, tr_go;

  // training stage: indices captured with the read, written one cycle later
  logic              s1_vld, s1_taken;
  logic [IDX_W-1:0]  s1_li;
  logic [HIST_W-1:0] s1_gi;

  // last written values, for a read that raced the write
  logic              fw_vld;
  logic [IDX_W-1:0]  fw_li;
  logic [HIST_W-1:0] fw_gi;
  ctr2_t             fw_l, fw_g, fw_c;

  ctr2_t             rd_l, rd_g, rd_c;
  ctr2_t             cur_l, cur_g, cur_c;
  ctr2_t             nxt_l, nxt_g, nxt_c;
  logic              lk_l, lk_g, lk_c;

  logic              we;
  logic [IDX_W-1:0]  wa_idx;
  logic [HIST_W-1:0] wa_hist;
  ctr2_t             wd_l, wd_g, wd_c;

  assign ready = ~busy;
  assign lk_go = pred_req & ~busy;
  assign tr_go = upd_req & ~busy;

  tbp_init_sweep #(.SW(SW)) u_sweep (
    .clk  (clk),
    .rst  (rst),
    .busy (busy),
    .idx  (sweep_idx)
  );

  tbp_hist_reg #(.HW(HIST_W)) u_hist (
    .clk      (clk),
    .rst      (rst),
    .shift_en (tr_go),
    .bit_in   (upd_taken),
    .hist     (ghist)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld   <= 1'b0;
      s1_taken <= 1'b0;
      s1_li    <= '0;
      s1_gi    <= '0;
      fw_vld   <= 1'b0;
      fw_li    <= '0;
      fw_gi    <= '0;
      fw_l     <= CTR_INIT;
      fw_g     <= CTR_INIT;
      fw_c     <= CTR_INIT;
      pred_vld <= 1'b0;
    end else begin
      s1_vld   <= tr_go;
      s1_taken <= upd_taken;
      s1_li    <= upd_pc;
      s1_gi    <= ghist;
      fw_vld   <= s1_vld;
      fw_li    <= s1_li;
      fw_gi    <= s1_gi;
      fw_l     <= nxt_l;
      fw_g     <= nxt_g;
      fw_c     <= nxt_c;
      pred_vld <= lk_go;
    end
  end

  // resolve the read-during-write race of back-to-back training
  always_comb begin
    cur_l = (fw_vld && fw_li == s1_li) ? fw_l : rd_l;
    cur_c = (fw_vld && fw_li == s1_li) ? fw_c : rd_c;
    cur_g = (fw_vld && fw_gi == s1_gi) ? fw_g : rd_g;
    nxt_l = ctr_step(cur_l, s1_taken);
    nxt_g = ctr_step(cur_g, s1_taken);
    nxt_c = sel_step(cur_c, cur_l[1] == s1_taken, cur_g[1] == s1_taken);
  end

  // write port shared between the init walk and training
  always_comb begin
    we = busy | s1_vld;
    if (busy) begin
      wa_idx  = sweep_idx[IDX_W-1:0];
      wa_hist = sweep_idx[HIST_W-1:0];
      wd_l    = CTR_INIT;
      wd_g    = CTR_INIT;
      wd_c    = CTR_INIT;
    end else begin
      wa_idx  = s1_li;
      wa_hist = s1_gi;
      wd_l    = nxt_l;
      wd_g    = nxt_g;
      wd_c    = nxt_c;
    end
  end

  tbp_ctr_table #(.AW(IDX_W)) u_loc_tab (
    .clk     (clk),
    .lk_addr (pred_pc),
    .lk_dir  (lk_l),
    .tr_addr (upd_pc),
    .tr_data (rd_l),
    .wr_en   (we),
    .wr_addr (wa_idx),
    .wr_data (wd_l)
  );

  tbp_ctr_table #(.AW(HIST_W)) u_glb_tab (
    .clk     (clk),
    .lk_addr (ghist),
    .lk_dir  (lk_g),
    .tr_addr (ghist),
    .tr_data (rd_g),
    .wr_en   (we),
    .wr_addr (wa_hist),
    .wr_data (wd_g)
  );

  tbp_ctr_table #(.AW(IDX_W)) u_sel_tab (
    .clk     (clk),
    .lk_addr (pred_pc),
    .lk_dir  (lk_c),
    .tr_addr (upd_pc),
    .tr_data (rd_c),
    .wr_en   (we),
    .wr_addr (wa_idx),
    .wr_data (wd_c)
  );

  assign pred_loc = lk_l;
  assign pred_glb = lk_g;
  assign pred_dir = lk_c ? lk_g : lk_l;

endmodule

// File: rtl/tbp_checks.sv
module tbp_checks #(
  parameter int HIST_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              ready,
  input logic              pred_req,
  input logic              pred_vld,
  input logic              pred_dir,
  input logic              pred_loc,
  input logic              pred_glb,
  input logic              upd_req,
  input logic              upd_taken,
  input logic [HIST_W-1:0] ghist
);

  // R1: once initialised, stays initialised
  assert_ready_holds_R1: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);

  // R2: a result only follows an accepted lookup
  assert_vld_follows_req_R2: assert property (@(posedge clk) disable iff (rst)
    pred_vld |-> $past(pred_req && ready));

  // R5: agreeing components leave no choice
  assert_agree_dir_R5: assert property (@(posedge clk) disable iff (rst)
    (pred_vld && pred_loc == pred_glb) |-> pred_dir == pred_loc);

  // R8: training shifts the outcome in at bit 0
  assert_hist_shift_R8: assert property (@(posedge clk) disable iff (rst)
    (ready && upd_req) |=> ghist == {$past(ghist[HIST_W-2:0]), $past(upd_taken)});

  // R8 / R10: history moves only on accepted training
  assert_hist_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !(ready && upd_req) |=> $stable(ghist));

  // R10: no result while initialising
  assert_no_vld_busy_R10: assert property (@(posedge clk) disable iff (rst)
    !ready |=> !pred_vld);

endmodule

bind tourney_bp tbp_checks #(.HIST_W(HIST_W)) u_tbp_checks (
  .clk       (clk),
  .rst       (rst),
  .ready     (ready),
  .pred_req  (pred_req),
  .pred_vld  (pred_vld),
  .pred_dir  (pred_dir),
  .pred_loc  (pred_loc),
  .pred_glb  (pred_glb),
  .upd_req   (upd_req),
  .upd_taken (upd_taken),
  .ghist     (ghist)
);

// File: tb/tourney_bp_bench.sv
module tourney_bp_bench;

  localparam int IW = 6;
  localparam int HW = 4;
  localparam int LN = 1 << IW;
  localparam int GN = 1 << HW;
  localparam int SN = (LN > GN) ? LN : GN;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ready;
  logic          pred_req = 1'b0;
  logic [IW-1:0] pred_pc = '0;
  logic          pred_vld, pred_dir, pred_loc, pred_glb;
  logic          upd_req = 1'b0;
  logic [IW-1:0] upd_pc = '0;
  logic          upd_taken = 1'b0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tourney_bp #(.IDX_W(IW), .HIST_W(HW)) u_tourney_bp (
    .clk (clk), .rst (rst), .ready (ready),
    .pred_req (pred_req), .pred_pc (pred_pc), .pred_vld (pred_vld),
    .pred_dir (pred_dir), .pred_loc (pred_loc), .pred_glb (pred_glb),
    .upd_req (upd_req), .upd_pc (upd_pc), .upd_taken (upd_taken)
  );

  // ---------------- behavioural reference ----------------
  int m_l [LN];
  int m_g [GN];
  int m_c [LN];
  int m_hist, m_cnt;
  bit d_vld, d_t;
  int d_li, d_gi;
  bit e_vld, e_dir, e_loc, e_glb, e_ready;

  function automatic int sat(input int v, input bit up);
    if (up) return (v == 3) ? 3 : v + 1;
    return (v == 0) ? 0 : v - 1;
  endfunction

  always @(posedge clk) begin
    bit rdy, lok, gok;
    if (rst) begin
      for (int i = 0; i < LN; i++) begin m_l[i] = 1; m_c[i] = 1; end
      for (int i = 0; i < GN; i++) m_g[i] = 1;
      m_hist = 0; m_cnt = 0; d_vld = 0; e_vld = 0; e_ready = 0;
    end else begin
      rdy = (m_cnt == SN);
      e_vld = rdy && pred_req;
      if (e_vld) begin
        e_loc = m_l[int'(pred_pc)] >= 2;
        e_glb = m_g[m_hist] >= 2;
        e_dir = (m_c[int'(pred_pc)] >= 2) ? e_glb : e_loc;
      end
      if (d_vld) begin
        lok = (m_l[d_li] >= 2) == d_t;
        gok = (m_g[d_gi] >= 2) == d_t;
        if (gok && !lok) m_c[d_li] = sat(m_c[d_li], 1'b1);
        if (lok && !gok) m_c[d_li] = sat(m_c[d_li], 1'b0);
        m_l[d_li] = sat(m_l[d_li], d_t);
        m_g[d_gi] = sat(m_g[d_gi], d_t);
      end
      d_vld = rdy && upd_req;
      d_li  = int'(upd_pc);
      d_gi  = m_hist;
      d_t   = upd_taken;
      if (d_vld) m_hist = ((m_hist << 1) | int'(upd_taken)) % GN;
      if (m_cnt < SN) m_cnt++;
      e_ready = (m_cnt == SN);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // lockstep comparison on every clock
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R1 ready", int'(ready), int'(e_ready));
      chk("R2 R10 pred_vld", int'(pred_vld), int'(e_vld));
      if (e_vld) begin
        chk("R3 pred_loc", int'(pred_loc), int'(e_loc));
        chk("R4 R8 pred_glb", int'(pred_glb), int'(e_glb));
        chk("R5 pred_dir", int'(pred_dir), int'(e_dir));
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000 && !done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog act=%0d exp=<200000 cycles", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic lookup(input int pc);
    pred_req = 1'b1; pred_pc = IW'(pc);
    @(negedge clk);
    pred_req = 1'b0;
  endtask

  task automatic train(input int pc, input bit t);
    upd_req = 1'b1; upd_pc = IW'(pc); upd_taken = t;
    @(negedge clk);
    upd_req = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ready low in reset", int'(ready), 0);
    rst = 1'b0;

    // traffic during the initialisation walk
    @(negedge clk);
    upd_req = 1'b1; upd_pc = 6'd3; upd_taken = 1'b1;
    pred_req = 1'b1; pred_pc = 6'd3;
    @(negedge clk);
    upd_req = 1'b0; pred_req = 1'b0;
    chk("R10 no result while busy", int'(pred_vld), 0);
    repeat (SN + 4) @(negedge clk);
    chk("R1 ready after walk", int'(ready), 1);
    lookup(3);
    chk("R10 training ignored (loc)", int'(pred_loc), 0);
    chk("R10 training ignored (glb)", int'(pred_glb), 0);
    chk("R1 init dir", int'(pred_dir), 0);

    // R3: per-address training, history now 0001
    train(5, 1'b1);
    @(negedge clk);
    lookup(5);
    chk("R3 loc after taken", int'(pred_loc), 1);
    chk("R4 glb at new history", int'(pred_glb), 0);
    chk("R5 selector 01 picks loc", int'(pred_dir), 1);

    // four not-taken bring history back to zero
    for (int i = 0; i < 4; i++) train(20, 1'b0);
    @(negedge clk);
    lookup(9);
    chk("R7 glb trained while loc selected", int'(pred_glb), 1);
    chk("R7 loc untouched entry", int'(pred_loc), 0);
    chk("R5 dir from loc", int'(pred_dir), 0);

    // only the history component right: selector moves to it
    train(9, 1'b1);
    @(negedge clk);
    lookup(9);
    chk("R6 loc trained", int'(pred_loc), 1);
    chk("R6 selector now picks glb", int'(pred_dir), int'(pred_glb));
    chk("R6 dir value", int'(pred_dir), 0);

    // R9: back-to-back training accumulates
    train(33, 1'b1); train(33, 1'b1); train(33, 1'b1); train(33, 1'b0);
    @(negedge clk);
    lookup(33);
    chk("R9 forwarded counter", int'(pred_loc), 1);

    // R9: visibility window
    upd_req = 1'b1; upd_pc = 6'd50; upd_taken = 1'b1;
    @(negedge clk);
    upd_req = 1'b0; pred_req = 1'b1; pred_pc = 6'd50;
    @(negedge clk);
    chk("R9 old value at t+1", int'(pred_loc), 0);
    @(negedge clk);
    pred_req = 1'b0;
    chk("R9 new value at t+2", int'(pred_loc), 1);

    // mixed traffic with a reset in the middle
    for (int i = 0; i < 3000; i++) begin
      pred_req  = $urandom_range(0, 1) == 1;
      pred_pc   = IW'($urandom_range(0, 15));
      upd_req   = $urandom_range(0, 2) != 0;
      upd_pc    = IW'($urandom_range(0, 15));
      upd_taken = $urandom_range(0, 3) != 0;
      rst       = (i == 1500 || i == 1501);
      @(negedge clk);
    end
    pred_req = 1'b0; upd_req = 1'b0; rst = 1'b0;
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule